// File: doc/BRIEF.md
# Three-Byte Serial Converter Conversion Sequencer

This block is a host-side SPI master that runs a single conversion on an external serial 8-bit analog-to-digital converter. A one-cycle `start` pulse, together with the channel and mode fields, begins the sequence. The block drops chip select and builds a command byte from those fields. It clocks out the command byte and then two zero bytes over one unbroken 24-bit frame. The converter's answer arrives in the last two received bytes. The block keeps it in a 16-bit window and takes the 8 result bits from inside that window.

The serial clock comes from the system clock through a parameterised divider. Each half period of the serial clock lasts `HALF_DIV` system clocks. The defaults give 500 kHz from 50 MHz. A budget counter limits the whole frame to `TIMEOUT_CYC` system clocks, which is 1 ms by default, so a stalled frame cannot let the converter's held sample droop. When the frame completes, `done` pulses for one cycle and `result` keeps its value until the next frame completes. When the budget runs out first, the frame is abandoned and `tmo_err` pulses instead.

Top module: `conv3_seq`

## Requirements
- R1: SPI mode 0. `sclk` is low whenever `cs_n` is high. `mosi` carries the first command bit before the first rising edge of `sclk`. The slave's `miso` is sampled on rising edges.
- R2: Each `sclk` half period lasts `HALF_DIV` system clocks. A frame has exactly 24 rising edges of `sclk`.
- R3: The command byte is sent MSB first. Bit 7 is 1. Bits 6:4 are `chan_sel`. Bit 3 is `unipolar`. Bit 2 is `single_ended`. Bits 1:0 are both 1, which selects an externally clocked conversion with no power-down.
- R4: After the command byte, 16 zero bits are sent. `cs_n` stays low without a break from the cycle after the start is accepted until the end of bit 24, and it rises exactly once per frame.
- R5: The first received byte has no effect on `result`.
- R6: The second and third received bytes form a window {byte2, byte3} whose MSB is received first. `result` is bits [13:6] of that window.
- R7: `done` is high for exactly one cycle. It is seen 48*`HALF_DIV`+1 system clocks after `start` is driven. `result` changes only together with `done`.
- R8: `busy` is high from the cycle after an accepted start until the frame ends. A `start` pulse while `busy` is high is ignored: the transmitted bits do not change and no extra `done` appears.
- R9: If `TIMEOUT_CYC` system clocks pass after acceptance before the frame completes, the frame is abandoned. `cs_n` goes high, `sclk` goes low, `busy` goes low and `tmo_err` pulses for one cycle. There is no `done` and `result` is unchanged.
- R10: A frame whose last falling `sclk` edge falls in the very cycle the budget expires counts as complete. It gives `done` and no `tmo_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that requests one conversion |
| chan_sel | input | 3 | Converter input channel |
| unipolar | input | 1 | 1 = unipolar coding, 0 = bipolar |
| single_ended | input | 1 | 1 = single-ended input, 0 = differential |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | One-cycle budget-expired pulse |
| result | output | 8 | Last completed conversion result |

## Verification
The end of the frame and the expiry of the time budget can land on the same system clock edge: the last falling `sclk` edge and the final budget count coincide. The bench provokes this with two extra instances that use a short divider. One has a budget exactly equal to the frame length, and the other has a budget one cycle shorter. The first must show `done` and no `tmo_err` at the computed cycle. The second must show `tmo_err` one cycle earlier, with no `done` and its result left untouched.

// File: rtl/conv3_seq.sv
module conv3_seq #(
  parameter int HALF_DIV    = 50,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] chan_sel,
  input  logic       unipolar,
  input  logic       single_ended,
  input  logic       miso,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic       tmo_err,
  output logic [7:0] result
);
  localparam int FRAME_BITS = 24;
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int TMO_W      = $clog2(TIMEOUT_CYC + 1);
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic             run;
  logic [DIV_W-1:0] div;
  logic [BIT_W-1:0] bitn;
  logic [TMO_W-1:0] tcnt;
  logic [7:0]       tx;
  logic [15:0]      rx;

  wire tick     = (div == DIV_LAST);
  wire fall_now = tick && sclk;
  wire last_now = fall_now && (bitn == BIT_LAST);
  wire expire   = (tcnt == TMO_LAST);

  assign busy = run;
  assign mosi = run & tx[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      div     <= '0;
      bitn    <= '0;
      tcnt    <= '0;
      tx      <= '0;
      rx      <= '0;
      done    <= 1'b0;
      tmo_err <= 1'b0;
      result  <= '0;
    end else begin
      done    <= 1'b0;
      tmo_err <= 1'b0;
      if (!run) begin
        if (start) begin
          run  <= 1'b1;
          cs_n <= 1'b0;
          tx   <= {1'b1, chan_sel, unipolar, single_ended, 2'b11};
          div  <= '0;
          bitn <= '0;
          tcnt <= '0;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
        if (last_now) begin
          run    <= 1'b0;
          sclk   <= 1'b0;
          cs_n   <= 1'b1;
          done   <= 1'b1;
          result <= rx[13:6];
        end else if (expire) begin
          run     <= 1'b0;
          sclk    <= 1'b0;
          cs_n    <= 1'b1;
          tmo_err <= 1'b1;
        end else if (tick) begin
          div  <= '0;
          sclk <= ~sclk;
          if (!sclk) begin
            rx <= {rx[14:0], miso};
          end else begin
            bitn <= bitn + 1'b1;
            tx   <= {tx[6:0], 1'b0};
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv3_seq_chk.sv
module conv3_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       cs_n,
  input logic       busy,
  input logic       done,
  input logic       tmo_err,
  input logic [7:0] result
);
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_cs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (done || tmo_err));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));
  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (!busy && cs_n && !sclk));
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && tmo_err));
endmodule

bind conv3_seq conv3_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(busy),
  .done(done), .tmo_err(tmo_err), .result(result)
);

// File: tb/conv3_seq_bench.sv
module conv3_seq_bench;
  localparam int H  = 50;
  localparam int H2 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan_sel = '0;
  logic unipolar = 1'b0, single_ended = 1'b0;
  logic sclk, cs_n, mosi, busy, done, tmo_err, miso;
  logic [7:0] result;
  logic [23:0] slv = '0;
  logic [23:0] cap = '0;
  int nrise = 0, ncs = 0, ndone = 0;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  logic start2 = 1'b0;
  logic sclk2, cs2, mosi2, busy2, done2, tmo2;
  logic sclk3, cs3, mosi3, busy3, done3, tmo3;
  logic [7:0] res2, res3;

  always #10 clk = ~clk;

  assign miso = slv[23];
  always @(negedge sclk) if (!cs_n) slv <= {slv[22:0], 1'b0};
  always @(posedge sclk) begin cap <= {cap[22:0], mosi}; nrise <= nrise + 1; end
  always @(posedge cs_n) ncs <= ncs + 1;
  always @(posedge clk) if (done) ndone <= ndone + 1;

  conv3_seq #(.HALF_DIV(H), .TIMEOUT_CYC(50000)) u_conv3_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .unipolar(unipolar), .single_ended(single_ended), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done),
    .tmo_err(tmo_err), .result(result));

  conv3_seq #(.HALF_DIV(H2), .TIMEOUT_CYC(48*H2)) u_exact (
    .clk(clk), .rst_n(rst_n), .start(start2), .chan_sel(3'd5),
    .unipolar(1'b1), .single_ended(1'b1), .miso(1'b1),
    .sclk(sclk2), .cs_n(cs2), .mosi(mosi2), .busy(busy2), .done(done2),
    .tmo_err(tmo2), .result(res2));

  conv3_seq #(.HALF_DIV(H2), .TIMEOUT_CYC(48*H2-1)) u_short (
    .clk(clk), .rst_n(rst_n), .start(start2), .chan_sel(3'd5),
    .unipolar(1'b1), .single_ended(1'b1), .miso(1'b1),
    .sclk(sclk3), .cs_n(cs3), .mosi(mosi3), .busy(busy3), .done(done3),
    .tmo_err(tmo3), .result(res3));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_byte(input logic [2:0] s, input logic u, input logic g);
    return {1'b1, s, u, g, 2'b11};
  endfunction

  function automatic logic [7:0] pick(input logic [23:0] p);
    logic [15:0] w;
    w = p[15:0];
    return w[13:6];
  endfunction

  task automatic conv(input logic [2:0] s, input logic u, input logic g,
                      input logic [23:0] pat, input bit poke);
    int n, d0, r0, c0;
    slv = pat;
    d0 = ndone; r0 = nrise; c0 = ncs;
    @(negedge clk);
    chan_sel = s; unipolar = u; single_ended = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    chk("R8 busy after start", {31'd0, busy}, 32'd1);
    chk("R1 first bit set up", {31'd0, mosi}, 32'd1);
    while (!done && n < 10000) begin
      @(negedge clk);
      n++;
      if (poke && n == 700) begin
        start = 1'b1; chan_sel = ~s; unipolar = ~u; single_ended = ~g;
      end else start = 1'b0;
    end
    chk("R7 done timing", n, 48*H + 1);
    chk("R6 result", {24'd0, result}, {24'd0, pick(pat)});
    chk("R3 R4 frame bits", {8'd0, cap}, {8'd0, cmd_byte(s, u, g), 16'h0000});
    chk("R2 rise count", nrise - r0, 24);
    chk("R4 single release", ncs - c0, 1);
    @(negedge clk);
    chk("R7 done one cycle", {30'd0, done, busy}, 32'd0);
    chk("R8 one done", ndone - d0, 1);
    chk("R7 result held", {24'd0, result}, {24'd0, pick(pat)});
  endtask

  initial begin
    int seen_d2, seen_t2, seen_d3, seen_t3;
    logic [23:0] p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset idle", {27'd0, cs_n, sclk, busy, done, tmo_err}, {27'd0, 5'b10000});
    chk("R7 reset result", {24'd0, result}, 32'd0);

    conv(3'd7, 1'b1, 1'b1, 24'hA5_3FC0, 1'b0);
    conv(3'd0, 1'b0, 1'b0, 24'h00_0000, 1'b0);
    p = {8'h00, 16'h2A40};
    conv(3'd2, 1'b1, 1'b0, p, 1'b0);
    p[23:16] = 8'hFF;
    conv(3'd2, 1'b1, 1'b0, p, 1'b0);
    chk("R5 first byte ignored", {24'd0, result}, {24'd0, pick({8'h00, 16'h2A40})});
    conv(3'd4, 1'b0, 1'b1, $urandom(), 1'b1);
    for (int i = 0; i < 10; i++) begin
      logic [31:0] r;
      r = $urandom();
      conv(r[2:0], r[3], r[4], $urandom(), r[5]);
    end

    seen_d2 = 0; seen_t2 = 0; seen_d3 = 0; seen_t3 = 0;
    @(negedge clk);
    start2 = 1'b1;
    for (int n = 1; n < 300; n++) begin
      @(negedge clk);
      start2 = 1'b0;
      if (done2 && seen_d2 == 0) seen_d2 = n;
      if (tmo2 && seen_t2 == 0) seen_t2 = n;
      if (done3 && seen_d3 == 0) seen_d3 = n;
      if (tmo3 && seen_t3 == 0) begin
        seen_t3 = n;
        chk("R9 abort lines", {29'd0, cs3, sclk3, busy3}, 32'b100);
      end
    end
    chk("R10 exact budget done", seen_d2, 48*H2 + 1);
    chk("R10 exact budget no timeout", seen_t2, 0);
    chk("R9 timeout cycle", seen_t3, 48*H2);
    chk("R9 no done", seen_d3, 0);
    chk("R9 result unchanged", {24'd0, res3}, 32'd0);
    chk("R10 result", {24'd0, res2}, 32'hFF);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule